// File: doc/BRIEF.md
# Dual-domain timestamp counter

This block keeps the global time of a timed I/O system. A coarse counter advances once per clock of the fast I/O domain. A copy of that count is presented in the slower control domain, where the sequencing logic reads it and compares it against event times. The block also widens the control-domain count into a 64-bit timestamp. The coarse count fills the upper bits, and the low `FINE_W` bits are left as zero so that attached channels can express sub-cycle positions there.

The block is built in one of two modes, chosen by a parameter. In the shared-clock mode both ports see one clock. The counter can then be overwritten at run time from a load value, and the control-side copy is the I/O count itself. In the split-clock mode the counter only free-runs. The count reaches the control domain through a Gray-coded, double-synchronised path, so the copy there can lag the true count but can never run ahead of it or step backwards.

A registered "earliest schedulable time" output gives the control-side count plus a fixed margin, for use by an output scheduler. Elaboration stops if the global fine width is smaller than the widest fine field of any attached channel.

Top module: `tsc_dual_domain`

## Requirements
- R1: While reset is held, `coarse_io`, `coarse_ctl` and `full_ts_ctl` read 0 and `min_sched_ctl` reads the margin (16).
- R2: With no load applied, `coarse_io` grows by exactly one on every `io_clk` rising edge after reset, wrapping modulo 2^(64-FINE_W).
- R3: In shared-clock mode, `load_stb` high at an `io_clk` edge makes `coarse_io` equal `load_val` after that edge, in either direction. Counting then resumes from the loaded value, and all-ones wraps to 0.
- R4: In split-clock mode, `load_stb` and `load_val` have no effect on `coarse_io`.
- R5: In split-clock mode, successive `coarse_ctl` values never decrease while both resets are released.
- R6: In split-clock mode, `coarse_ctl` is never greater than `coarse_io` at the same instant. Once settled, it trails by at most 2 I/O cycles plus 4 control cycles' worth of counts.
- R7: In shared-clock mode, `coarse_ctl` equals `coarse_io` in every cycle.
- R8: `full_ts_ctl` equals `coarse_ctl` shifted left by `FINE_W`, with the low `FINE_W` bits zero.
- R9: `min_sched_ctl` equals the `coarse_ctl` value from the previous `ctl_clk` cycle plus 16, modulo 2^(64-FINE_W).
- R10: Asserting `ctl_rst_n` alone leaves the I/O-domain counter counting undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| io_clk | input | 1 | Fast I/O-domain clock |
| io_rst_n | input | 1 | Active-low asynchronous reset of the I/O domain |
| ctl_clk | input | 1 | Control-domain clock (tied to io_clk in shared-clock mode) |
| ctl_rst_n | input | 1 | Active-low asynchronous reset of the control domain |
| load_stb | input | 1 | Load request, honoured in shared-clock mode only |
| load_val | input | 64-FINE_W | Coarse value written by a load |
| coarse_io | output | 64-FINE_W | Coarse count in the I/O domain |
| coarse_ctl | output | 64-FINE_W | Coarse count as seen by the control domain |
| full_ts_ctl | output | 64 | Control-side 64-bit timestamp, fine field zero |
| min_sched_ctl | output | 64-FINE_W | Control-side count plus scheduling margin, registered |

## Verification
`coarse_io` and any load take effect on the `io_clk` edge after the inputs are presented. The bench drives on falling edges and compares against a behavioural model one half-cycle later. In shared-clock mode `coarse_ctl` and `full_ts_ctl` follow in that same cycle, and `min_sched_ctl` holds the value seen one cycle earlier plus 16. In split-clock mode the copy passes through one I/O register and two control flops. The bench therefore does not predict it cycle by cycle. At each control falling edge it checks order against the previous sample, the upper bound against the live I/O count, and the settled lag bound, starting four control cycles after reset. It also checks the registered margin against the previous sample.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned TS_W = 64;

  typedef enum logic {
    TSC_SPLIT  = 1'b0,
    TSC_SHARED = 1'b1
  } tsc_mode_e;
endpackage

// File: rtl/tsc_coarse_ctr.sv
module tsc_coarse_ctr #(
  parameter int unsigned CW       = 61,
  parameter bit          LOADABLE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (LOADABLE && load_stb) cnt_d = load_val;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tsc_gray_xfer.sv
module tsc_gray_xfer #(
  parameter int unsigned W      = 61,
  parameter int unsigned STAGES = 2
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic [W-1:0] bin_src,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] bin_dst
);
  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [W-1:0] from_gray(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] gray_d;
  logic [W-1:0] gray_q;
  logic [W-1:0] sync_q [STAGES];

  always_comb gray_d = to_gray(bin_src);

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gray_q <= '0;
    else            gray_q <= gray_d;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = gray_q;
    end else begin : g_next
      always_comb stage_d = sync_q[s-1];
    end
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) sync_q[s] <= '0;
      else            sync_q[s] <= stage_d;
    end
  end

  assign bin_dst = from_gray(sync_q[STAGES-1]);
endmodule

// File: rtl/tsc_dual_domain.sv
module tsc_dual_domain
  import tsc_pkg::*;
#(
  parameter int unsigned FINE_W        = 3,
  parameter int unsigned CHAN_FINE_MAX = 3,
  parameter tsc_mode_e   MODE          = TSC_SPLIT,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned MIN_MARGIN    = 16,
  localparam int unsigned CW           = TS_W - FINE_W
) (
  input  logic            io_clk,
  input  logic            io_rst_n,
  input  logic            ctl_clk,
  input  logic            ctl_rst_n,
  input  logic            load_stb,
  input  logic [CW-1:0]   load_val,
  output logic [CW-1:0]   coarse_io,
  output logic [CW-1:0]   coarse_ctl,
  output logic [TS_W-1:0] full_ts_ctl,
  output logic [CW-1:0]   min_sched_ctl
);
  if (FINE_W < CHAN_FINE_MAX) begin : g_fine_chk
    $error("global fine width smaller than a channel fine width");
  end

  localparam bit LOADABLE = (MODE == TSC_SHARED);

  tsc_coarse_ctr #(.CW(CW), .LOADABLE(LOADABLE)) ctr_i (
    .clk      (io_clk),
    .rst_n    (io_rst_n),
    .load_stb (load_stb),
    .load_val (load_val),
    .cnt      (coarse_io)
  );

  if (MODE == TSC_SHARED) begin : g_shared
    assign coarse_ctl = coarse_io;
  end else begin : g_split
    tsc_gray_xfer #(.W(CW), .STAGES(SYNC_STAGES)) xfer_i (
      .src_clk   (io_clk),
      .src_rst_n (io_rst_n),
      .bin_src   (coarse_io),
      .dst_clk   (ctl_clk),
      .dst_rst_n (ctl_rst_n),
      .bin_dst   (coarse_ctl)
    );
  end

  logic [TS_W-1:0] ctl_wide;
  assign ctl_wide    = TS_W'(coarse_ctl);
  assign full_ts_ctl = ctl_wide << FINE_W;

  logic [CW-1:0] min_d;
  logic [CW-1:0] min_q;

  always_comb min_d = coarse_ctl + CW'(MIN_MARGIN);

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) min_q <= CW'(MIN_MARGIN);
    else            min_q <= min_d;
  end

  assign min_sched_ctl = min_q;
endmodule

// File: rtl/tsc_dual_domain_chk.sv
module tsc_dual_domain_chk
  import tsc_pkg::*;
#(
  parameter int unsigned CW         = 61,
  parameter tsc_mode_e   MODE       = TSC_SPLIT,
  parameter int unsigned MIN_MARGIN = 16
) (
  input logic          io_clk,
  input logic          io_rst_n,
  input logic          ctl_clk,
  input logic          ctl_rst_n,
  input logic          load_stb,
  input logic [CW-1:0] load_val,
  input logic [CW-1:0] coarse_io,
  input logic [CW-1:0] coarse_ctl,
  input logic [CW-1:0] min_sched_ctl
);
  logic io_live;
  logic ctl_live;

  always_ff @(posedge io_clk or negedge io_rst_n) begin
    if (!io_rst_n) io_live <= 1'b0;
    else           io_live <= 1'b1;
  end

  always_ff @(posedge ctl_clk or negedge ctl_rst_n) begin
    if (!ctl_rst_n) ctl_live <= 1'b0;
    else            ctl_live <= 1'b1;
  end

  assert_reset_margin_R1: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    !ctl_live |-> min_sched_ctl == CW'(MIN_MARGIN));

  // R2 in both modes, R4 in split-clock mode (load ignored there)
  assert_step_one_R2: assert property (@(posedge io_clk) disable iff (!io_rst_n)
    (io_live && !(MODE == TSC_SHARED && $past(load_stb))) |->
      coarse_io == CW'($past(coarse_io) + 1'b1));

  assert_margin_R9: assert property (@(posedge ctl_clk) disable iff (!ctl_rst_n)
    ctl_live |-> min_sched_ctl == CW'($past(coarse_ctl) + CW'(MIN_MARGIN)));

  if (MODE == TSC_SHARED) begin : g_shared_chk
    assert_load_R3: assert property (@(posedge io_clk) disable iff (!io_rst_n)
      (io_live && $past(load_stb)) |-> coarse_io == $past(load_val));
  end else begin : g_split_chk
    assert_monotonic_R5: assert property (@(posedge ctl_clk)
      disable iff (!ctl_rst_n || !io_rst_n)
      ctl_live |-> coarse_ctl >= $past(coarse_ctl));
  end
endmodule

bind tsc_dual_domain tsc_dual_domain_chk #(
  .CW(CW), .MODE(MODE), .MIN_MARGIN(MIN_MARGIN)
) chk_i (
  .io_clk        (io_clk),
  .io_rst_n      (io_rst_n),
  .ctl_clk       (ctl_clk),
  .ctl_rst_n     (ctl_rst_n),
  .load_stb      (load_stb),
  .load_val      (load_val),
  .coarse_io     (coarse_io),
  .coarse_ctl    (coarse_ctl),
  .min_sched_ctl (min_sched_ctl)
);

// File: tb/tsc_dual_domain_tb_top.sv
`timescale 1ns/1ps
module tsc_dual_domain_tb_top;
  import tsc_pkg::*;

  localparam int unsigned FINE = 3;
  localparam int unsigned CW   = 64 - FINE;
  localparam logic [63:0] MASK = (64'd1 << CW) - 64'd1;
  localparam logic [63:0] LAG_MAX = 64'd14; // 2 io + ceil(4*14/5) io counts

  logic io_clk  = 1'b0;
  logic ctl_clk = 1'b0;
  always #2.5 io_clk  = ~io_clk;
  always #7   ctl_clk = ~ctl_clk;

  logic          a_io_rst_n = 1'b0;
  logic          a_ctl_rst_n = 1'b0;
  logic          s_rst_n = 1'b0;
  logic          load_stb = 1'b0;
  logic [CW-1:0] load_val = '0;

  logic [CW-1:0] a_cio, a_cctl, a_min, s_cio, s_cctl, s_min;
  logic [63:0]   a_full, s_full;

  tsc_dual_domain #(.FINE_W(FINE), .MODE(TSC_SPLIT)) dut_i (
    .io_clk(io_clk), .io_rst_n(a_io_rst_n), .ctl_clk(ctl_clk), .ctl_rst_n(a_ctl_rst_n),
    .load_stb(load_stb), .load_val(load_val), .coarse_io(a_cio), .coarse_ctl(a_cctl),
    .full_ts_ctl(a_full), .min_sched_ctl(a_min));

  tsc_dual_domain #(.FINE_W(FINE), .MODE(TSC_SHARED)) dut_s_i (
    .io_clk(io_clk), .io_rst_n(s_rst_n), .ctl_clk(io_clk), .ctl_rst_n(s_rst_n),
    .load_stb(load_stb), .load_val(load_val), .coarse_io(s_cio), .coarse_ctl(s_cctl),
    .full_ts_ctl(s_full), .min_sched_ctl(s_min));

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // behavioural reference models, advanced on each io edge
  logic [63:0] m_a = 64'd0;
  logic [63:0] m_s = 64'd0;
  logic [63:0] m_s_prev = 64'd0;

  always @(posedge io_clk) begin
    if (!a_io_rst_n) m_a = 64'd0;
    else             m_a = (m_a + 64'd1) & MASK;
    m_s_prev = m_s;
    if (!s_rst_n)      m_s = 64'd0;
    else if (load_stb) m_s = 64'(load_val);
    else               m_s = (m_s + 64'd1) & MASK;
  end

  // per-clock compare of the I/O-domain results
  always @(negedge io_clk) begin
    check(64'(a_cio) == m_a, "R2/R4", 64'(a_cio), m_a);
    check(64'(s_cio) == m_s, "R3", 64'(s_cio), m_s);
    check(64'(s_cctl) == m_s, "R7", 64'(s_cctl), m_s);
    check(s_full == (m_s << FINE), "R8", s_full, m_s << FINE);
    check(64'(s_min) == ((m_s_prev + 64'd16) & MASK), "R9", 64'(s_min),
          (m_s_prev + 64'd16) & MASK);
  end

  // control-domain checks of the split-clock instance
  logic [63:0] prev_ctl = 64'd0;
  bit          have_prev = 1'b0;
  int          live_cnt = 0;

  always @(negedge ctl_clk) begin
    if (!a_ctl_rst_n || !a_io_rst_n) begin
      have_prev = 1'b0;
      live_cnt  = 0;
    end else begin
      check(64'(a_cctl) <= 64'(a_cio), "R6", 64'(a_cctl), 64'(a_cio));
      if (live_cnt >= 4)
        check(64'(a_cio) - 64'(a_cctl) <= LAG_MAX, "R6",
              64'(a_cio) - 64'(a_cctl), LAG_MAX);
      if (have_prev) begin
        check(64'(a_cctl) >= prev_ctl, "R5", 64'(a_cctl), prev_ctl);
        check(64'(a_min) == ((prev_ctl + 64'd16) & MASK), "R9", 64'(a_min),
              (prev_ctl + 64'd16) & MASK);
      end
      check(a_full == (64'(a_cctl) << FINE), "R8", a_full, 64'(a_cctl) << FINE);
      prev_ctl  = 64'(a_cctl);
      have_prev = 1'b1;
      live_cnt++;
    end
  end

  task automatic load_once(input logic [CW-1:0] v);
    @(negedge io_clk);
    load_stb = 1'b1;
    load_val = v;
    @(negedge io_clk);
    load_stb = 1'b0;
    check(64'(s_cio) == 64'(v), "R3", 64'(s_cio), 64'(v));
  endtask

  initial begin
    repeat (4) @(negedge io_clk);
    // R1: reset state of both instances
    check(64'(a_cio) == 0, "R1", 64'(a_cio), 0);
    check(64'(a_cctl) == 0, "R1", 64'(a_cctl), 0);
    check(a_full == 0, "R1", a_full, 0);
    check(64'(a_min) == 16, "R1", 64'(a_min), 16);
    check(64'(s_cio) == 0, "R1", 64'(s_cio), 0);
    check(64'(s_min) == 16, "R1", 64'(s_min), 16);

    @(negedge io_clk);
    a_io_rst_n = 1'b1;
    s_rst_n    = 1'b1;
    @(negedge ctl_clk);
    a_ctl_rst_n = 1'b1;
    repeat (200) @(negedge io_clk);

    // R3: forward jump, backward jump, back-to-back loads, wrap from all-ones
    load_once(CW'(1000));
    repeat (20) @(negedge io_clk);
    load_once(CW'(5));
    repeat (20) @(negedge io_clk);
    @(negedge io_clk);
    load_stb = 1'b1; load_val = CW'(77);
    @(negedge io_clk);
    check(64'(s_cio) == 64'd77, "R3", 64'(s_cio), 64'd77);
    load_val = CW'(300);
    @(negedge io_clk);
    load_stb = 1'b0;
    check(64'(s_cio) == 64'd300, "R3", 64'(s_cio), 64'd300);
    check(64'(a_cio) == m_a, "R4", 64'(a_cio), m_a);
    load_once(CW'(MASK));
    @(negedge io_clk);
    check(64'(s_cio) == 64'd0, "R3", 64'(s_cio), 64'd0);
    repeat (100) @(negedge io_clk);

    // R10: control reset alone leaves the I/O counter running
    @(negedge ctl_clk);
    a_ctl_rst_n = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge io_clk);
      check(64'(a_cio) == m_a, "R10", 64'(a_cio), m_a);
    end
    check(64'(a_cctl) == 0, "R10", 64'(a_cctl), 0);
    @(negedge ctl_clk);
    a_ctl_rst_n = 1'b1;
    repeat (400) @(negedge io_clk);
    check(64'(a_cio) == m_a, "R10", 64'(a_cio), m_a);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge io_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule